// File: doc/BRIEF.md
# Key-Guarded Clock Configuration Registers

This unit holds two 8-bit control registers for the clock and power logic that sits next to it. The source register chooses the 32 kHz reference and the clocking mode. The power register carries an operating mode and a CPU clock divider. The unit sits on a simple synchronous bus: each cycle with the write enable high is one write, and read data follows the address within the same cycle.

Neither register can be changed by a single stray store. A new value takes effect only inside a three-write frame. First comes an unlock key write, then the data write to the register, then a confirm key write. Each register has its own pair of key values. Any other write in between cancels the frame and drops the staged data. The committed fields drive dedicated output pins.

Word addresses on `bus_addr`:

| Address | Function |
|---|---|
| 0x0 | source unlock key |
| 0x1 | source register |
| 0x2 | source confirm key |
| 0x4 | power unlock key |
| 0x5 | power register |
| 0x6 | power confirm key |

Any other address is unused.

Top module: `clk_cfg_guard`

## Requirements
- R1: After reset, the source register reads 0x21 (`ref_internal`=1, `clk_mode`=01) and the power register reads 0x03 (`op_mode`=000, `cpu_div`=011).
- R2: The source register updates only after this sequence: 0xAA written to address 0x0, then data written to 0x1, then 0x55 written to 0x2. The new value appears on the outputs in the cycle after the confirm write. Field positions: bit 5 is `ref_internal` (1 = internal oscillator, 0 = external crystal) and bits 1:0 are `clk_mode` (01 = PLL, 11 = external clock pin).
- R3: The power register updates only after this sequence: 0x01 written to 0x4, then data written to 0x5, then 0xF4 written to 0x6. Bits 6:4 are `op_mode` and bits 2:0 are `cpu_div`.
- R4: Until the confirm key is written, a register and its outputs keep their old value, including while a value is staged.
- R5: A wrong unlock value or a wrong confirm value aborts the frame. A correct confirm key written later on its own commits nothing.
- R6: Any write to a different address in the middle of a frame aborts that frame, including a write to the other register's addresses.
- R7: Reserved bits are cleared when a value is committed and always read as zero. These are source bits 7:6 and 4:2, and power bits 7 and 3.
- R8: Reads of the four key addresses and of unused addresses return 0x00. Reads of 0x1 and 0x5 return the live register value in the same cycle.
- R9: A write to a control register without a preceding unlock key is ignored.
- R10: Cycles with the write enable low do not disturb a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 4 | word address |
| bus_we | input | 1 | write strobe, one write per high cycle |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for `bus_addr`, combinational |
| ref_internal | output | 1 | 32 kHz reference select |
| clk_mode | output | 2 | clocking mode |
| op_mode | output | 3 | operating mode |
| cpu_div | output | 3 | CPU clock divider |

## Verification
The hold properties assume that the only event allowed to change a live register is a write with the correct confirm value to its confirm address. Every other combination of address, data and strobe must leave it stable. The stimulus reaches that event only through complete frames or through deliberately broken ones, such as a wrong key, an intruding write or a missing unlock. Inputs change only at the falling edge, so each bus write is seen at exactly one rising edge.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SRC_KEY1 = 4'h0;
    localparam logic [ADDR_W-1:0] A_SRC_REG  = 4'h1;
    localparam logic [ADDR_W-1:0] A_SRC_KEY2 = 4'h2;
    localparam logic [ADDR_W-1:0] A_PWR_KEY1 = 4'h4;
    localparam logic [ADDR_W-1:0] A_PWR_REG  = 4'h5;
    localparam logic [ADDR_W-1:0] A_PWR_KEY2 = 4'h6;

    localparam logic [DATA_W-1:0] SRC_UNLOCK  = 8'hAA;
    localparam logic [DATA_W-1:0] SRC_CONFIRM = 8'h55;
    localparam logic [DATA_W-1:0] PWR_UNLOCK  = 8'h01;
    localparam logic [DATA_W-1:0] PWR_CONFIRM = 8'hF4;

    localparam logic [DATA_W-1:0] SRC_MASK  = 8'h23;
    localparam logic [DATA_W-1:0] PWR_MASK  = 8'h77;
    localparam logic [DATA_W-1:0] SRC_RESET = 8'h21;
    localparam logic [DATA_W-1:0] PWR_RESET = 8'h03;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARMED  = 2'd1,
        PH_STAGED = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [DATA_W-1:0]   stage;
        logic [DATA_W-1:0]   live;
    } seq_state_t;
endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
    import clk_cfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 4'h1,
    parameter logic [ADDR_W-1:0] KEY2_ADDR = 4'h2,
    parameter logic [DATA_W-1:0] KEY1_VAL  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY2_VAL  = 8'h55,
    parameter logic [DATA_W-1:0] FIELD_MASK = 8'hFF,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] live_val
);
    seq_state_t st_d, st_q;

    logic hit_key1, hit_reg, hit_key2;

    always_comb begin
        hit_key1 = bus_we && (bus_addr == KEY1_ADDR) && (bus_wdata == KEY1_VAL);
        hit_reg  = bus_we && (bus_addr == REG_ADDR);
        hit_key2 = bus_we && (bus_addr == KEY2_ADDR) && (bus_wdata == KEY2_VAL);

        st_d = st_q;
        if (bus_we) begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (hit_key1) begin
                        st_d.phase = PH_ARMED;
                    end
                end
                PH_ARMED: begin
                    if (hit_reg) begin
                        st_d.phase = PH_STAGED;
                        st_d.stage = bus_wdata & FIELD_MASK;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.stage = '0;
                    end
                end
                PH_STAGED: begin
                    if (hit_key2) begin
                        st_d.live = st_q.stage;
                    end
                    st_d.phase = PH_IDLE;
                    st_d.stage = '0;
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.stage = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.stage <= '0;
            st_q.live  <= RESET_VAL & FIELD_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_val = st_q.live;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import clk_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] pwr_val,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        unique case (rd_addr)
            A_SRC_REG: rd_data = src_val;
            A_PWR_REG: rd_data = pwr_val;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/clk_cfg_guard.sv
module clk_cfg_guard
    import clk_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ref_internal,
    output logic [1:0]        clk_mode,
    output logic [2:0]        op_mode,
    output logic [2:0]        cpu_div
);
    logic [DATA_W-1:0] src_live;
    logic [DATA_W-1:0] pwr_live;

    cfg_key_seq #(
        .KEY1_ADDR (A_SRC_KEY1),
        .REG_ADDR  (A_SRC_REG),
        .KEY2_ADDR (A_SRC_KEY2),
        .KEY1_VAL  (SRC_UNLOCK),
        .KEY2_VAL  (SRC_CONFIRM),
        .FIELD_MASK(SRC_MASK),
        .RESET_VAL (SRC_RESET)
    ) u_src_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .live_val (src_live)
    );

    cfg_key_seq #(
        .KEY1_ADDR (A_PWR_KEY1),
        .REG_ADDR  (A_PWR_REG),
        .KEY2_ADDR (A_PWR_KEY2),
        .KEY1_VAL  (PWR_UNLOCK),
        .KEY2_VAL  (PWR_CONFIRM),
        .FIELD_MASK(PWR_MASK),
        .RESET_VAL (PWR_RESET)
    ) u_pwr_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .live_val (pwr_live)
    );

    cfg_read_mux u_rd_mux (
        .rd_addr(bus_addr),
        .src_val(src_live),
        .pwr_val(pwr_live),
        .rd_data(bus_rdata)
    );

    assign ref_internal = src_live[5];
    assign clk_mode     = src_live[1:0];
    assign op_mode      = pwr_live[6:4];
    assign cpu_div      = pwr_live[2:0];
endmodule

// File: rtl/clk_cfg_guard_chk.sv
module clk_cfg_guard_chk
    import clk_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] src_live,
    input logic [DATA_W-1:0] pwr_live
);
    logic src_confirm, pwr_confirm, key_addr;

    assign src_confirm = bus_we && bus_addr == A_SRC_KEY2 && bus_wdata == SRC_CONFIRM;
    assign pwr_confirm = bus_we && bus_addr == A_PWR_KEY2 && bus_wdata == PWR_CONFIRM;
    assign key_addr = bus_addr == A_SRC_KEY1 || bus_addr == A_SRC_KEY2 ||
                      bus_addr == A_PWR_KEY1 || bus_addr == A_PWR_KEY2;

    assert_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !src_confirm |=> $stable(src_live));

    assert_pwr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_confirm |=> $stable(pwr_live));

    assert_src_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_live & ~SRC_MASK) == '0);

    assert_pwr_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_live & ~PWR_MASK) == '0);

    assert_key_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_addr |-> bus_rdata == '0);

    assert_src_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == A_SRC_REG |-> bus_rdata == src_live);
endmodule

bind clk_cfg_guard clk_cfg_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_live (src_live),
    .pwr_live (pwr_live)
);

// File: tb/clk_cfg_guard_test.sv
`timescale 1ns/1ps
module clk_cfg_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h3;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ref_internal;
    logic [1:0] clk_mode;
    logic [2:0] op_mode;
    logic [2:0] cpu_div;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    clk_cfg_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_internal(ref_internal),
        .clk_mode(clk_mode), .op_mode(op_mode), .cpu_div(cpu_div)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h3;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_addr = 4'h3;
    endtask

    task automatic t_reset();
        check("R1 ref_internal", {7'd0, ref_internal}, 8'h01);
        check("R1 clk_mode", {6'd0, clk_mode}, 8'h01);
        check("R1 op_mode", {5'd0, op_mode}, 8'h00);
        check("R1 cpu_div", {5'd0, cpu_div}, 8'h03);
        rd_chk("R1 src read", 4'h1, 8'h21);
        rd_chk("R1 pwr read", 4'h5, 8'h03);
    endtask

    task automatic t_src_commit();
        wr(4'h0, 8'hAA);
        wr(4'h1, 8'h03);
        rd_chk("R4 src before confirm", 4'h1, 8'h21);
        check("R4 clk_mode before confirm", {6'd0, clk_mode}, 8'h01);
        wr(4'h2, 8'h55);
        check("R2 ref_internal", {7'd0, ref_internal}, 8'h00);
        check("R2 clk_mode", {6'd0, clk_mode}, 8'h03);
        rd_chk("R2 src read", 4'h1, 8'h03);
    endtask

    task automatic t_pwr_commit();
        wr(4'h4, 8'h01);
        wr(4'h5, 8'h45);
        check("R4 op_mode before confirm", {5'd0, op_mode}, 8'h00);
        wr(4'h6, 8'hF4);
        check("R3 op_mode", {5'd0, op_mode}, 8'h04);
        check("R3 cpu_div", {5'd0, cpu_div}, 8'h05);
        rd_chk("R3 pwr read", 4'h5, 8'h45);
    endtask

    task automatic t_reserved();
        wr(4'h0, 8'hAA); wr(4'h1, 8'hFF); wr(4'h2, 8'h55);
        rd_chk("R7 src reserved", 4'h1, 8'h23);
        wr(4'h4, 8'h01); wr(4'h5, 8'hFF); wr(4'h6, 8'hF4);
        rd_chk("R7 pwr reserved", 4'h5, 8'h77);
    endtask

    task automatic t_wrong_key();
        wr(4'h0, 8'hAB); wr(4'h1, 8'h01); wr(4'h2, 8'h55);
        rd_chk("R5 bad unlock", 4'h1, 8'h23);
        wr(4'h0, 8'hAA); wr(4'h1, 8'h00); wr(4'h2, 8'h56);
        rd_chk("R5 bad confirm", 4'h1, 8'h23);
        wr(4'h2, 8'h55);
        rd_chk("R5 late confirm alone", 4'h1, 8'h23);
        wr(4'h4, 8'h01); wr(4'h5, 8'h00); wr(4'h6, 8'h55);
        rd_chk("R5 pwr bad confirm", 4'h5, 8'h77);
    endtask

    task automatic t_cross();
        wr(4'h0, 8'hAA); wr(4'h5, 8'h00); wr(4'h1, 8'h01); wr(4'h2, 8'h55);
        rd_chk("R6 src after intruding write", 4'h1, 8'h23);
        rd_chk("R6 pwr untouched", 4'h5, 8'h77);
        wr(4'h0, 8'hAA); wr(4'h1, 8'h01); wr(4'h7, 8'h00); wr(4'h2, 8'h55);
        rd_chk("R6 src intrude before confirm", 4'h1, 8'h23);
    endtask

    task automatic t_nokey();
        wr(4'h5, 8'h11); wr(4'h6, 8'hF4);
        rd_chk("R9 pwr without unlock", 4'h5, 8'h77);
        wr(4'h1, 8'h01);
        rd_chk("R9 src direct write", 4'h1, 8'h23);
    endtask

    task automatic t_reads();
        wr(4'h4, 8'h01);
        idle(3);
        rd_chk("R10 read mid frame", 4'h5, 8'h77);
        wr(4'h5, 8'h12);
        idle(2);
        wr(4'h6, 8'hF4);
        check("R10 op_mode", {5'd0, op_mode}, 8'h01);
        check("R10 cpu_div", {5'd0, cpu_div}, 8'h02);
    endtask

    task automatic t_keyread();
        rd_chk("R8 key 0x0", 4'h0, 8'h00);
        rd_chk("R8 key 0x2", 4'h2, 8'h00);
        rd_chk("R8 key 0x4", 4'h4, 8'h00);
        rd_chk("R8 key 0x6", 4'h6, 8'h00);
        rd_chk("R8 unused 0xF", 4'hF, 8'h00);
        rd_chk("R8 pwr live", 4'h5, 8'h12);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_src_commit();
        t_pwr_commit();
        t_reserved();
        t_wrong_key();
        t_cross();
        t_nokey();
        t_reads();
        t_keyread();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule